// File: doc/BRIEF.md
# Multi-Format Serial Audio Receive Port

This block receives stereo PCM audio over a three-wire serial link made of a bit clock, a frame clock and one data line, and turns each stereo frame into a pair of parallel sample words. It understands three framings: I2S, left-justified and right-justified. The word length can be set anywhere from 16 to 24 bits. Data is taken on the rising bit-clock edge, and each channel word arrives MSB first. Within one frame clock period the left word comes first and the right word follows.

The port can act as clock master. It then divides its system clock down to a bit clock and makes 64 bit clocks per frame, with the frame clock changing level every 32 bit clocks. It can also act as slave and follow clocks that another device drives. A tri-state control turns off the drivers for both clock pins, so several masters can share one clock bus. While the drivers are off, the port runs as a slave on the external clocks. All serial inputs, and the clocks the port makes itself, go through the same synchronizer before deserialisation, so the data is sampled at a fixed point relative to the clocks.

Top module: `sap_rx`

## Requirements
- R1: Framing comes from `fmt_sw` when `fmt_sw_en` is 1: 2'b00 selects left-justified, 2'b01 selects I2S, 2'b10 selects right-justified and 2'b11 selects left-justified. When `fmt_sw_en` is 0, `fmt_pin` low selects left-justified and `fmt_pin` high selects I2S.
- R2: In I2S framing, frame clock low marks the left channel. The MSB is the second bit after a frame clock change.
- R3: In left-justified framing, frame clock high marks the left channel. The MSB is the first bit after a frame clock change.
- R4: In right-justified framing, frame clock high marks the left channel. The LSB is the last bit before the next frame clock change.
- R5: The word length is `wlen_in` clamped to the range 16..24. Values below 16 act as 16 and values above 24 act as 24.
- R6: Serial data is taken on rising bit-clock edges. Data that changes only on falling edges is received without error.
- R7: After the right word of a frame completes, `valid_o` is high for exactly one cycle. In that cycle `left_o` and `right_o` carry the frame's two words, sign-extended to 24 bits. The outputs hold until the next strobe.
- R8: When clock drive is enabled, `bclk_o` has a period of 2*DIV system cycles. `lrck_o` changes only on falling `bclk_o` edges, every 32 bit clocks, which gives 64 bit clocks per frame.
- R9: `bclk_oe` and `lrck_oe` are 1 exactly when `master_en` is 1 and `tristate` is 0, one cycle after those inputs. Otherwise the port deserialises `bclk_in`/`lrck_in`.
- R10: No strobe is issued until a frame clock change has been seen and a complete left word has been captured after it. The first strobe carries the first complete frame.
- R11: During and right after reset, `valid_o` is 0, `left_o` and `right_o` are 0, and both clock enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the master clock for division |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Request to generate and drive the serial clocks |
| tristate | input | 1 | Turns off the clock drivers and forces slave operation |
| fmt_pin | input | 1 | Hardware format select: 0 left-justified, 1 I2S |
| fmt_sw_en | input | 1 | Use `fmt_sw` instead of `fmt_pin` |
| fmt_sw | input | 2 | Software format code (see R1) |
| wlen_in | input | 5 | Requested word length in bits |
| bclk_in | input | 1 | External bit clock |
| lrck_in | input | 1 | External frame clock |
| sdata_in | input | 1 | Serial data |
| bclk_o | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Driver enable for the bit clock pin |
| lrck_o | output | 1 | Generated frame clock |
| lrck_oe | output | 1 | Driver enable for the frame clock pin |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe for a new stereo frame |

## Verification
A wrong bit counter or a wrong channel level shows up at the first strobe after a frame clock change. The words come out shifted by one position, swapped between channels, or with the wrong sign extension. That is visible within one frame, so the bench compares every strobe against independently built samples and also counts the strobes. A framing or arming fault would produce a missing frame, an extra zero frame or a first frame out of order; each of these shows up in the strobe count or in the first comparison. A fault in the clock generator shows up in the bit-clock period or in the number of bit clocks between frame clock changes, which the bench measures on the pins within one frame.

// File: rtl/sap_pkg.sv
package sap_pkg;
  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_RJ  = 2'd2
  } fmt_e;
endpackage

// File: rtl/sap_clkgen.sv
module sap_clkgen #(
  parameter int DIV       = 4,
  parameter int HALF_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic bclk,
  output logic lrck
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(HALF_BITS);

  logic [DW-1:0] divcnt;
  logic [BW-1:0] bitcnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      divcnt <= '0;
      bitcnt <= '0;
      bclk   <= 1'b0;
      lrck   <= 1'b0;
    end else if (divcnt == DW'(DIV - 1)) begin
      divcnt <= '0;
      bclk   <= ~bclk;
      if (bclk) begin
        if (bitcnt == BW'(HALF_BITS - 1)) begin
          bitcnt <= '0;
          lrck   <= ~lrck;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end else begin
      divcnt <= divcnt + 1'b1;
    end
  end

  AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$stable(lrck)) |-> $fell(bclk)); // R8
endmodule

// File: rtl/sap_sync.sv
module sap_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s > 0) ? s - 1 : 0];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sap_deser.sv
module sap_deser
  import sap_pkg::*;
#(
  parameter int MAX_W = 24,
  parameter int MIN_W = 16,
  parameter int WL_W  = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_rise,
  input  logic             lrck,
  input  logic             sdata,
  input  fmt_e             fmt,
  input  logic [WL_W-1:0]  wlen,
  output logic [MAX_W-1:0] left_o,
  output logic [MAX_W-1:0] right_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             have_prev, prev_lrck, armed, left_got;
  logic [CNT_W-1:0] cnt;
  logic [MAX_W-1:0] sh, left_hold;

  logic             fr_edge, armed_n, left_lvl, take, to_left;
  logic [CNT_W-1:0] cnt_n;
  logic [MAX_W-1:0] sh_n, word;
  int               start;

  function automatic logic [MAX_W-1:0] sext(input logic [MAX_W-1:0] x,
                                            input logic [WL_W-1:0] w);
    logic [MAX_W-1:0] r;
    for (int i = 0; i < MAX_W; i++)
      r[i] = (i < int'(w)) ? x[i] : x[w - 1'b1];
    return r;
  endfunction

  always_comb begin
    fr_edge  = have_prev && (lrck != prev_lrck);
    cnt_n    = fr_edge ? '0 : ((cnt == CMAX) ? cnt : cnt + 1'b1);
    armed_n  = armed | fr_edge;
    left_lvl = (fmt == FMT_I2S) ? 1'b0 : 1'b1;
    start    = (fmt == FMT_I2S) ? 1 : 0;
    sh_n     = {sh[MAX_W-2:0], sdata};
    if (fmt == FMT_RJ) begin
      take    = fr_edge && armed;
      word    = sext(sh, wlen);
      to_left = (prev_lrck == left_lvl);
    end else begin
      take    = armed_n && (int'(cnt_n) == start + int'(wlen) - 1);
      word    = sext(sh_n, wlen);
      to_left = (lrck == left_lvl);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_lrck <= 1'b0;
      armed     <= 1'b0;
      left_got  <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bit_rise) begin
        have_prev <= 1'b1;
        prev_lrck <= lrck;
        armed     <= armed_n;
        cnt       <= cnt_n;
        sh        <= sh_n;
        if (take) begin
          if (to_left) begin
            left_hold <= word;
            left_got  <= 1'b1;
          end else if (left_got) begin
            left_o   <= left_hold;
            right_o  <= word;
            valid_o  <= 1'b1;
            left_got <= 1'b0;
          end
        end
      end
    end
  end

  AST_WLEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(wlen) >= MIN_W) && (int'(wlen) <= MAX_W)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R7
  AST_VALID_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> $past(bit_rise)); // R6
endmodule

// File: rtl/sap_rx.sv
module sap_rx
  import sap_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int HALF_BITS = 32,
  parameter int MAX_W     = 24,
  parameter int MIN_W     = 16,
  parameter int WL_W      = 5,
  parameter int SYNC_ST   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_en,
  input  logic             tristate,
  input  logic             fmt_pin,
  input  logic             fmt_sw_en,
  input  logic [1:0]       fmt_sw,
  input  logic [WL_W-1:0]  wlen_in,
  input  logic             bclk_in,
  input  logic             lrck_in,
  input  logic             sdata_in,
  output logic             bclk_o,
  output logic             bclk_oe,
  output logic             lrck_o,
  output logic             lrck_oe,
  output logic [MAX_W-1:0] left_o,
  output logic [MAX_W-1:0] right_o,
  output logic             valid_o
);
  localparam int CNT_W = $clog2(2 * HALF_BITS);

  logic            drive, s_bclk, s_lrck, s_data, s_bclk_q, bit_rise;
  logic [2:0]      sync_d, sync_q;
  logic [WL_W-1:0] wlen_eff;
  fmt_e            fmt;

  assign drive = master_en && !tristate;

  sap_clkgen #(.DIV(DIV), .HALF_BITS(HALF_BITS)) u_gen (
    .clk(clk), .rst(rst), .en(drive), .bclk(bclk_o), .lrck(lrck_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_oe  <= 1'b0;
      lrck_oe  <= 1'b0;
      s_bclk_q <= 1'b0;
    end else begin
      bclk_oe  <= drive;
      lrck_oe  <= drive;
      s_bclk_q <= s_bclk;
    end
  end

  assign sync_d = drive ? {bclk_o, lrck_o, sdata_in} : {bclk_in, lrck_in, sdata_in};

  sap_sync #(.N(3), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst(rst), .d(sync_d), .q(sync_q)
  );

  assign {s_bclk, s_lrck, s_data} = sync_q;
  assign bit_rise = s_bclk && !s_bclk_q;

  always_comb begin
    if (fmt_sw_en) begin
      case (fmt_sw)
        2'b01:   fmt = FMT_I2S;
        2'b10:   fmt = FMT_RJ;
        default: fmt = FMT_LJ;
      endcase
    end else begin
      fmt = fmt_pin ? FMT_I2S : FMT_LJ;
    end
    if (wlen_in < WL_W'(MIN_W))      wlen_eff = WL_W'(MIN_W);
    else if (wlen_in > WL_W'(MAX_W)) wlen_eff = WL_W'(MAX_W);
    else                             wlen_eff = wlen_in;
  end

  sap_deser #(.MAX_W(MAX_W), .MIN_W(MIN_W), .WL_W(WL_W), .CNT_W(CNT_W)) u_deser (
    .clk(clk), .rst(rst), .bit_rise(bit_rise), .lrck(s_lrck), .sdata(s_data),
    .fmt(fmt), .wlen(wlen_eff), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  AST_TRISTATE_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(tristate) |-> (!bclk_oe && !lrck_oe)); // R9
  AST_MASTER_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(master_en) && !$past(tristate)) |-> (bclk_oe && lrck_oe)); // R9
endmodule

// File: tb/sim_sap_rx.sv
`timescale 1ns/1ps
module sim_sap_rx;
  import sap_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int HALF = 32;
  localparam int NF   = 3;
  localparam int H    = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic master_en = 0, tristate = 0, fmt_pin = 0, fmt_sw_en = 0;
  logic [1:0] fmt_sw = 0;
  logic [4:0] wlen_in = 5'd24;
  logic bclk_in = 0, lrck_in = 0, sdata_in = 0;
  logic bclk_o, bclk_oe, lrck_o, lrck_oe, valid_o;
  logic [23:0] left_o, right_o;

  int errors = 0, checks = 0;
  logic [23:0] L [NF];
  logic [23:0] R [NF];
  bit mon_en = 0;
  int mon_idx = 0, mon_w = 24;
  string cur_req = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  sap_rx #(.DIV(DIV), .HALF_BITS(HALF)) u0 (
    .clk(clk), .rst(rst), .master_en(master_en), .tristate(tristate),
    .fmt_pin(fmt_pin), .fmt_sw_en(fmt_sw_en), .fmt_sw(fmt_sw), .wlen_in(wlen_in),
    .bclk_in(bclk_in), .lrck_in(lrck_in), .sdata_in(sdata_in),
    .bclk_o(bclk_o), .bclk_oe(bclk_oe), .lrck_o(lrck_o), .lrck_oe(lrck_oe),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] expv(logic [23:0] v, int w);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  function automatic logic tx_bit(int f, bit is_left, int pos, fmt_e fm, int w);
    logic [23:0] v;
    int p;
    if (f < 0 || f >= NF) return 1'b0;
    v = is_left ? L[f] : R[f];
    case (fm)
      FMT_I2S: p = pos - 1;
      FMT_RJ:  p = pos - (HALF - w);
      default: p = pos;
    endcase
    if (p >= 0 && p < w) return v[w-1-p];
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (mon_en && valid_o) begin
      if (mon_idx < NF) begin
        check({cur_req, " R7 R10 left"},  left_o,  expv(L[mon_idx], mon_w));
        check({cur_req, " R7 R10 right"}, right_o, expv(R[mon_idx], mon_w));
      end
      mon_idx++;
    end
  end

  task automatic fill(int seed);
    logic [31:0] s = 32'h1234_5678 ^ seed;
    for (int i = 0; i < NF; i++) begin
      s = s * 32'd1103515245 + 32'd12345; L[i] = s[27:4];
      s = s * 32'd1103515245 + 32'd12345; R[i] = s[29:6];
    end
  endtask

  task automatic setup(bit men, bit tri_s, bit pin, bit swen, logic [1:0] sw,
                       logic [4:0] wl, bit lr_idle);
    @(negedge clk);
    rst = 1; master_en = men; tristate = tri_s; fmt_pin = pin;
    fmt_sw_en = swen; fmt_sw = sw; wlen_in = wl;
    bclk_in = 0; lrck_in = lr_idle; sdata_in = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic finish_case(string req);
    repeat (30) @(negedge clk);
    mon_en = 0;
    check({req, " R10 frame count"}, 24'(mon_idx), 24'(NF));
  endtask

  task automatic run_master(string req, int w, fmt_e fm, int seed);
    int f = -1, pos = 0;
    logic prevl, lvl;
    fill(seed);
    lvl = (fm == FMT_I2S) ? 1'b0 : 1'b1;
    cur_req = req; mon_w = w; mon_idx = 0; mon_en = 1;
    prevl = lrck_o;
    while (!(f == NF && pos >= 4)) begin
      @(negedge bclk_o);
      #1;
      if (lrck_o !== prevl) begin
        pos = 0;
        if (lrck_o == lvl) f++;
      end else pos++;
      prevl = lrck_o;
      sdata_in = tx_bit(f, lrck_o == lvl, pos, fm, w);
    end
    finish_case(req);
  endtask

  task automatic send_half(int f, bit is_left, logic lvl, fmt_e fm, int w);
    for (int pos = 0; pos < HALF; pos++) begin
      @(negedge clk);
      bclk_in = 0;
      lrck_in = is_left ? lvl : ~lvl;
      sdata_in = tx_bit(f, is_left, pos, fm, w);
      repeat (H) @(negedge clk);
      bclk_in = 1;
      repeat (H - 1) @(negedge clk);
    end
  endtask

  task automatic run_slave(string req, int w, fmt_e fm, int seed);
    logic lvl;
    fill(seed);
    lvl = (fm == FMT_I2S) ? 1'b0 : 1'b1;
    cur_req = req; mon_w = w; mon_idx = 0; mon_en = 1;
    send_half(-1, 0, lvl, fm, w);
    for (int f = 0; f < NF; f++) begin
      send_half(f, 1, lvl, fm, w);
      send_half(f, 0, lvl, fm, w);
    end
    send_half(NF, 1, lvl, fm, w);
    @(negedge clk); bclk_in = 0;
    finish_case(req);
  endtask

  // R11: reset state
  task automatic t_reset();
    @(negedge clk);
    rst = 1; master_en = 1; tristate = 0;
    repeat (3) @(negedge clk);
    check("R11 valid", 24'(valid_o), 24'd0);
    check("R11 left", left_o, 24'd0);
    check("R11 right", right_o, 24'd0);
    check("R11 oe", 24'({bclk_oe, lrck_oe}), 24'd0);
    rst = 0;
    repeat (2) @(negedge clk);
    check("R9 oe on in master", 24'({bclk_oe, lrck_oe}), 24'd3);
  endtask

  // R8: generated clock timing
  task automatic t_clocks();
    time t0;
    int n = 0;
    setup(1, 0, 0, 0, 2'b00, 5'd24, 1'b0);
    @(posedge bclk_o); t0 = $time;
    @(posedge bclk_o);
    check("R8 bclk period", 24'(($time - t0) / CLK_PERIOD), 24'(2 * DIV));
    @(posedge lrck_o);
    while (lrck_o) begin
      @(posedge bclk_o or negedge lrck_o);
      if (lrck_o && bclk_o) n++;
    end
    check("R8 bits per half", 24'(n), 24'(HALF));
  endtask

  initial begin
    t_reset();
    t_clocks();
    setup(1, 0, 0, 1, 2'b00, 5'd24, 1'b0); run_master("R1 R3 R6 lj24", 24, FMT_LJ, 1);
    setup(1, 0, 1, 0, 2'b11, 5'd16, 1'b0); run_master("R1 R2 i2s16 pin", 16, FMT_I2S, 2);
    setup(1, 0, 0, 1, 2'b10, 5'd20, 1'b0); run_master("R1 R4 rj20", 20, FMT_RJ, 3);
    setup(1, 0, 0, 0, 2'b10, 5'd31, 1'b0); run_master("R1 R5 lj clamp31", 24, FMT_LJ, 4);
    setup(1, 0, 0, 1, 2'b11, 5'd18, 1'b0); run_master("R1 lj code3 w18", 18, FMT_LJ, 5);
    setup(1, 1, 0, 1, 2'b01, 5'd24, 1'b1);
    check("R9 oe off tristate", 24'({bclk_oe, lrck_oe}), 24'd0);
    run_slave("R9 R2 slave i2s24", 24, FMT_I2S, 6);
    setup(0, 0, 1, 1, 2'b10, 5'd4, 1'b0); run_slave("R9 R4 R5 slave rj clamp4", 16, FMT_RJ, 7);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired (R7 not reached)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule